// File: doc/BRIEF.md
# Legacy Framed-Packet to AXI4-Stream Bridge

This block sits between a producer that speaks an older framed-packet protocol and a consumer that takes AXI4-Stream. On the legacy side every strobe is active low: the source signals a valid word with its ready strobe, marks the first and final words of a frame with start and end strobes, and qualifies the final word with a one-bit remainder code. The destination-ready strobe goes back to the source. On the stream side the signals are active high. The bridge inverts the strobes, passes data and backpressure straight through with no added latency, and turns the remainder code into a byte-enable mask.

AXI4-Stream has no start marker of its own, so the bridge works out where each packet begins. It does this from the history of accepted beats carrying tlast, and puts the result on a tuser bit. The bridge also compares the legacy start strobe with the position it works out. Any disagreement sets a sticky framing-error flag, which stays set until a synchronous clear.

Top module: `legacy_axis_bridge`

## Requirements
- R1: In the same cycle, `m_tvalid` equals the inverse of `leg_src_rdy_n`, `m_tlast` equals the inverse of `leg_eof_n`, and `m_tdata` equals `leg_data`.
- R2: In the same cycle, `leg_dst_rdy_n` equals the inverse of `m_tready`.
- R3: A beat transfers only in a cycle where `m_tvalid` and `m_tready` are both high. In any other cycle the legacy start strobe and the end strobe have no effect: `m_tuser` and `frame_err` keep their values into the next cycle.
- R4: When `m_tlast` is low, `m_tkeep` is 8'hFF whatever the value of `leg_rem`.
- R5: When `m_tlast` is high, `m_tkeep` is 8'h0F if `leg_rem` is 0 (low four bytes valid) and 8'hFF if `leg_rem` is 1 (all eight bytes valid).
- R6: While reset is asserted and after it is released, `m_tuser[0]` is 1 until the first transfer, so the first accepted beat is a start of packet.
- R7: In the cycle after a transfer with `m_tlast` high, `m_tuser[0]` is 1. In the cycle after a transfer with `m_tlast` low, it is 0.
- R8: A transfer in which `leg_sof_n` is low while `m_tuser[0]` is 0 sets `frame_err` in the next cycle.
- R9: A transfer in which `leg_sof_n` is high while `m_tuser[0]` is 1 sets `frame_err` in the next cycle.
- R10: Once set, `frame_err` stays high until a cycle with `err_clr` high, after which it reads 0. A clear in the same cycle as a framing fault wins.
- R11: While reset is asserted, `frame_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| leg_src_rdy_n | input | 1 | Legacy source word valid, active low |
| leg_dst_rdy_n | output | 1 | Legacy destination ready, active low |
| leg_sof_n | input | 1 | Legacy start-of-frame strobe, active low |
| leg_eof_n | input | 1 | Legacy end-of-frame strobe, active low |
| leg_data | input | 64 | Legacy data word |
| leg_rem | input | 1 | Remainder code for the final word: 0 = low 4 bytes, 1 = 8 bytes |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the consumer |
| m_tdata | output | 64 | Stream data |
| m_tkeep | output | 8 | Stream byte enables |
| m_tlast | output | 1 | Stream end of packet |
| m_tuser | output | 1 | Bit 0: start of packet, rebuilt from tlast history |
| err_clr | input | 1 | Synchronous clear of the framing-error flag |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions check several rules on every cycle. The start flag follows the last transfer's tlast and holds through stalls. Mid-packet beats carry a full keep mask. The error flag rises only after a mismatched transfer, stays set, and falls after a clear. Other behaviour only shows up in the bench's scenarios, where a behavioural model tracks the start position and the error flag beat by beat. These include the start flag after reset, the exact mask for each remainder code, start strobes that are ignored on idle or stalled cycles, and a clear that lands on the same cycle as a new fault.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int unsigned LSB_DATA_W = 64;
  localparam int unsigned LSB_BYTE_W = 8;
  localparam int unsigned LSB_USER_W = 1;
  localparam int unsigned LSB_USER_SOP = 0;

  typedef enum logic {
    REM_HALF = 1'b0,
    REM_FULL = 1'b1
  } lsb_rem_e;
endpackage

// File: rtl/lsb_keep_gen.sv
module lsb_keep_gen #(
  parameter int unsigned KEEP_W = 8
) (
  input  logic              last_i,
  input  logic              rem_i,
  output logic [KEEP_W-1:0] keep_o
);
  import lsb_pkg::*;
  localparam int unsigned HALF_W = KEEP_W / 2;

  logic full_word;

  always_comb begin
    full_word = !last_i || (rem_i == REM_FULL);
  end

  for (genvar b = 0; b < KEEP_W; b++) begin : g_byte
    if (b < HALF_W) begin : g_low
      assign keep_o[b] = 1'b1;
    end else begin : g_high
      assign keep_o[b] = full_word;
    end
  end
endmodule

// File: rtl/lsb_sop_tracker.sv
module lsb_sop_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_i,
  input  logic last_i,
  output logic sop_o
);
  logic sop_q, sop_d, sop_en;

  always_comb begin
    sop_en = xfer_i;
    sop_d  = last_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sop_q <= 1'b1;
    end else if (sop_en) begin
      sop_q <= sop_d;
    end
  end

  assign sop_o = sop_q;

  a_sop_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && last_i) |=> sop_o);
  a_sop_mid_packet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && !last_i) |=> !sop_o);
  a_sop_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(sop_o));
endmodule

// File: rtl/lsb_frame_check.sv
module lsb_frame_check (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_i,
  input  logic sof_i,
  input  logic sop_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q, err_d, err_en, mismatch;

  always_comb begin
    mismatch = xfer_i && (sof_i != sop_i);
    err_en   = clr_i || mismatch;
    err_d    = !clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign err_o = err_q;

  a_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && sof_i && !sop_i && !clr_i) |=> err_o);
  a_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && !sof_i && sop_i && !clr_i) |=> err_o);
  a_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o);
  a_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !err_o);
  a_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(xfer_i));
endmodule

// File: rtl/legacy_axis_bridge.sv
module legacy_axis_bridge #(
  parameter int unsigned DATA_W = lsb_pkg::LSB_DATA_W,
  parameter int unsigned USER_W = lsb_pkg::LSB_USER_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     leg_src_rdy_n,
  output logic                     leg_dst_rdy_n,
  input  logic                     leg_sof_n,
  input  logic                     leg_eof_n,
  input  logic [DATA_W-1:0]        leg_data,
  input  logic                     leg_rem,
  output logic                     m_tvalid,
  input  logic                     m_tready,
  output logic [DATA_W-1:0]        m_tdata,
  output logic [DATA_W/8-1:0]      m_tkeep,
  output logic                     m_tlast,
  output logic [USER_W-1:0]        m_tuser,
  input  logic                     err_clr,
  output logic                     frame_err
);
  import lsb_pkg::*;
  localparam int unsigned KEEP_W = DATA_W / LSB_BYTE_W;

  logic valid_hi, last_hi, sof_hi, xfer, sop;

  always_comb begin
    valid_hi = !leg_src_rdy_n;
    last_hi  = !leg_eof_n;
    sof_hi   = !leg_sof_n;
    xfer     = valid_hi && m_tready;
  end

  assign m_tvalid      = valid_hi;
  assign m_tlast       = last_hi;
  assign m_tdata       = leg_data;
  assign leg_dst_rdy_n = !m_tready;

  lsb_keep_gen #(.KEEP_W(KEEP_W)) u_keep (
    .last_i (last_hi),
    .rem_i  (leg_rem),
    .keep_o (m_tkeep)
  );

  lsb_sop_tracker u_sop (
    .clk    (clk),
    .rst_n  (rst_n),
    .xfer_i (xfer),
    .last_i (last_hi),
    .sop_o  (sop)
  );

  lsb_frame_check u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .xfer_i (xfer),
    .sof_i  (sof_hi),
    .sop_i  (sop),
    .clr_i  (err_clr),
    .err_o  (frame_err)
  );

  for (genvar u = 0; u < USER_W; u++) begin : g_user
    if (u == LSB_USER_SOP) begin : g_sop
      assign m_tuser[u] = sop;
    end else begin : g_zero
      assign m_tuser[u] = 1'b0;
    end
  end

  a_keep_full_midpacket_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tlast |-> (&m_tkeep));
  a_user_stable_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> $stable(m_tuser));
endmodule

// File: tb/test_legacy_axis_bridge.sv
module test_legacy_axis_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        leg_src_rdy_n, leg_dst_rdy_n, leg_sof_n, leg_eof_n, leg_rem;
  logic [63:0] leg_data;
  logic        m_tvalid, m_tready, m_tlast, err_clr, frame_err;
  logic [63:0] m_tdata;
  logic [7:0]  m_tkeep;
  logic [0:0]  m_tuser;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit exp_sop;
  bit exp_err;

  always #2 clk = !clk;

  legacy_axis_bridge i_legacy_axis_bridge (
    .clk(clk), .rst_n(rst_n),
    .leg_src_rdy_n(leg_src_rdy_n), .leg_dst_rdy_n(leg_dst_rdy_n),
    .leg_sof_n(leg_sof_n), .leg_eof_n(leg_eof_n),
    .leg_data(leg_data), .leg_rem(leg_rem),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tuser(m_tuser),
    .err_clr(err_clr), .frame_err(frame_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive active-high intents, check outputs, then update model at the edge.
  task automatic beat(input bit v, input bit r, input bit s, input bit e,
                      input bit rm, input bit c, input logic [63:0] d);
    logic [7:0] exp_keep;
    leg_src_rdy_n = !v;
    m_tready      = r;
    leg_sof_n     = !s;
    leg_eof_n     = !e;
    leg_rem       = rm;
    err_clr       = c;
    leg_data      = d;
    #1;
    exp_keep = (e && !rm) ? 8'h0F : 8'hFF;
    chk("R1 tvalid", m_tvalid, v);
    chk("R1 tlast", m_tlast, e);
    chk("R1 tdata", m_tdata, d);
    chk("R2 dst_rdy_n", leg_dst_rdy_n, !r);
    chk(e ? "R5 tkeep last" : "R4 tkeep mid", m_tkeep, exp_keep);
    chk("R7 tuser sop", m_tuser, exp_sop);
    chk("R8/R10 frame_err", frame_err, exp_err);
    @(posedge clk);
    if (c) exp_err = 1'b0;
    else if (v && r && (s != exp_sop)) exp_err = 1'b1;
    if (v && r) exp_sop = e;
    @(negedge clk);
  endtask

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    leg_src_rdy_n = 1'b1; m_tready = 1'b0; leg_sof_n = 1'b1; leg_eof_n = 1'b1;
    leg_rem = 1'b0; err_clr = 1'b0; leg_data = '0;
    exp_sop = 1'b1; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 tuser in reset", m_tuser, 1'b1);
    chk("R11 frame_err in reset", frame_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 tuser after reset", m_tuser, 1'b1);

    // R3: start strobe on idle and stalled cycles is ignored
    beat(0, 1, 1, 1, 0, 0, 64'h11);
    beat(1, 0, 0, 1, 0, 0, 64'h22);
    chk("R3 idle strobes ignored err", frame_err, 1'b0);
    chk("R3 idle strobes ignored sop", m_tuser, 1'b1);

    // Three-beat packet with stall in the middle; rem toggled mid-packet (R4)
    beat(1, 1, 1, 0, 0, 0, 64'hA0A0_0000_0000_0001);
    beat(1, 0, 0, 0, 0, 0, 64'hA0A0_0000_0000_0002);
    beat(1, 0, 0, 0, 1, 0, 64'hA0A0_0000_0000_0002);
    beat(1, 1, 0, 0, 0, 0, 64'hA0A0_0000_0000_0002);
    beat(1, 1, 0, 1, 0, 0, 64'hA0A0_0000_0000_0003);
    chk("R7 sop after last", m_tuser, 1'b1);

    // Single-beat packets with each remainder code (R5)
    beat(1, 1, 1, 1, 1, 0, 64'hB1);
    beat(1, 1, 1, 1, 0, 0, 64'hB2);
    chk("R10 no error yet", frame_err, 1'b0);

    // R8: unexpected start strobe mid-packet
    beat(1, 1, 1, 0, 0, 0, 64'hC1);
    beat(1, 1, 1, 1, 1, 0, 64'hC2);
    chk("R8 err set", frame_err, 1'b1);
    beat(0, 0, 0, 0, 0, 0, 64'h0);
    chk("R10 err sticky", frame_err, 1'b1);
    beat(0, 0, 0, 0, 0, 1, 64'h0);
    chk("R10 err cleared", frame_err, 1'b0);

    // R9: missing start strobe at packet start
    beat(1, 1, 0, 1, 1, 0, 64'hD1);
    chk("R9 err set", frame_err, 1'b1);
    beat(0, 0, 0, 0, 0, 1, 64'h0);
    // R10: clear wins over simultaneous fault
    beat(1, 1, 0, 1, 0, 1, 64'hD2);
    chk("R10 clear wins", frame_err, 1'b0);

    // Mixed stream against the model
    for (int i = 0; i < 400; i++) begin
      bit v, r, e, s;
      v = ($urandom % 4) != 0;
      r = ($urandom % 3) != 0;
      e = ($urandom % 4) == 0;
      s = (($urandom % 25) == 0) ? !exp_sop : exp_sop;
      beat(v, r, s, e, 1'($urandom), ($urandom % 30) == 0, {$urandom, $urandom});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule